// File: doc/BRIEF.md
# Flash Page Write-Protection Controller

This block sits between a processor's register bus and a flash array and decides which pages may be programmed or erased. Software sees seven registers behind a three-bit select. The registers hold a page address or key half, a data or key half, a mode byte, a command port, a status word, a volatile protection mask and a persistent protection mask. From these the block drives a per-page write-enable vector. It also issues program, page-erase and mass-erase operations to the array over a valid/ready channel, and it refuses any operation aimed at a page that is write-disabled.

Protection has two layers. The volatile mask is lost on every reset. The persistent mask and a 32-bit software key model non-volatile storage. These two survive a warm reset and are cleared only by a blank-device initialisation or by a mass erase. A key can be stored only once. After that, every change to either mask has to present the same key. The reserved key 0xDEADDEAD makes the persistent lock permanent, and only a mass erase clears it.

The operation channel follows valid/ready rules. Once `op_valid` rises, it stays high and `op_kind`/`op_page` stay stable until a cycle in which `op_ready` is also high. The array may hold `op_ready` low for as long as it needs, and the command remains busy the whole time.

Top module: `fwp_ctrl`

## Requirements
- R1: With both resets low and then released, select 5 and select 6 read 0xFFFFFFFF, status (select 4) reads 0, every `page_wr_en` bit is 1 and `op_valid` is 0.
- R2: Mask bit g covers pages 2g and 2g+1 and is active low. `page_wr_en[p]` is 0 exactly when bit p/2 is 0 in the volatile mask (select 5) or the persistent mask (select 6 read-back). The vector follows a mask change in the cycle after it.
- R3: While no key is stored, a write to select 5 replaces the volatile mask. A warm reset (`rst_n` low, `nv_init_n` high) returns the volatile mask to all ones, and the stored key and persistent mask are kept.
- R4: The protect command needs mode register (select 2) bits [6:5] = 10 and bit 3 = 1, and code 0x0C written to select 3. With those in place and no key stored, the key {select 0 [15:0], select 1 [15:0]} is stored and the mask staged by the last accepted write to select 6 becomes the persistent mask. Status bit 2 (busy) is 1 for 1+PROT_CYCLES cycles, starting in the cycle after the command write. At completion, status bit 0 (done) and bit 3 (key stored) are 1.
- R5: A protect command with the mode bits wrong is busy for exactly one cycle, then sets status bits 0 and 1 (fail), and leaves the key and both masks unchanged.
- R6: While a key is stored, a write to select 5 or select 6 takes effect only if {select 0, select 1} equals the stored key. Otherwise it has no effect.
- R7: While a key is stored, a protect command presenting a different key fails as in R5. A protect command presenting the matching key replaces the persistent mask and keeps the key.
- R8: A stored key of 0xDEADDEAD sets status bit 4, and from then on every protect command fails. Only a mass erase (code 0x05) returns the key to 0xFFFFFFFF, which clears status bits 3 and 4, and the persistent mask to all ones.
- R9: Program (0x02) and page erase (0x03) target page select 0 bits [14:9]. If that page is write-disabled, the command fails and no operation is issued. Otherwise `op_valid` rises one cycle after the command is captured, with `op_kind` 0 = program or 1 = page erase. A mass erase issues `op_kind` 2 with page 0. The operation holds stable until `op_ready`, and that handshake sets done.
- R10: A read of select 4 returns the status and clears bits 0 and 1 at the following clock edge. Bits 2 to 4 are not affected.
- R11: A command written while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Warm reset, active low; clears volatile state only |
| nv_init_n | input | 1 | Blank-device initialisation, active low; also clears key and persistent mask |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (status read clears sticky bits) |
| bus_sel | input | 3 | Register select: 0 addr, 1 data, 2 mode, 3 command, 4 status, 5 volatile mask, 6 persistent mask |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_sel`, combinational |
| page_wr_en | output | 64 | Per-page write enable to the array |
| busy | output | 1 | A command is in progress |
| op_valid | output | 1 | Operation request to the array |
| op_ready | input | 1 | Array accepts the operation |
| op_kind | output | 2 | 0 program, 1 page erase, 2 mass erase |
| op_page | output | 6 | Target page of the operation |

## Verification
The bench counts the cycles from each stimulus to its result. A mask write shows on `page_wr_en` and on read-back in the next cycle. A command captured at edge k is busy from that cycle and is evaluated at edge k+1. So a refused command already shows fail and no busy in the first read after the write, and an accepted array operation shows `op_valid` in that same cycle. A protect command stays busy through edge k+1+PROT_CYCLES. The bench reads status right after the write to see busy, and reads it again only after a wait longer than that window. Each expectation goes into the scoreboard queue in the cycle whose falling edge samples it, so every comparison falls in the cycle the count above predicts.

// File: rtl/fwp_pkg.sv
package fwp_pkg;
  localparam int DATA_W = 32;
  localparam int KEY_W  = 32;

  localparam logic [KEY_W-1:0] KEY_BLANK   = 32'hFFFF_FFFF;
  localparam logic [KEY_W-1:0] KEY_FOREVER = 32'hDEAD_DEAD;

  typedef enum logic [2:0] {
    RS_ADDR  = 3'd0,
    RS_DATA  = 3'd1,
    RS_MODE  = 3'd2,
    RS_CMD   = 3'd3,
    RS_STAT  = 3'd4,
    RS_VMASK = 3'd5,
    RS_PMASK = 3'd6
  } reg_sel_e;

  localparam logic [7:0] CMD_PROGRAM    = 8'h02;
  localparam logic [7:0] CMD_PAGE_ERASE = 8'h03;
  localparam logic [7:0] CMD_MASS_ERASE = 8'h05;
  localparam logic [7:0] CMD_PROTECT    = 8'h0C;

  typedef enum logic [1:0] {
    OP_PROGRAM    = 2'd0,
    OP_PAGE_ERASE = 2'd1,
    OP_MASS_ERASE = 2'd2
  } op_kind_e;

  typedef enum logic [1:0] {
    S_IDLE,
    S_EVAL,
    S_PROG,
    S_ISSUE
  } seq_state_e;

  localparam int ST_DONE    = 0;
  localparam int ST_FAIL    = 1;
  localparam int ST_BUSY    = 2;
  localparam int ST_KEYED   = 3;
  localparam int ST_FOREVER = 4;
endpackage

// File: rtl/fwp_keyvault.sv
module fwp_keyvault
  import fwp_pkg::*;
#(
  parameter int GROUPS = 32
) (
  input  logic              clk,
  input  logic              nv_init_n,
  input  logic              commit,
  input  logic [KEY_W-1:0]  new_key,
  input  logic [GROUPS-1:0] new_mask,
  input  logic              wipe,
  output logic [KEY_W-1:0]  key_q,
  output logic [GROUPS-1:0] pmask_q,
  output logic              keyed,
  output logic              forever_lock
);
  // Non-volatile model: only a blank-device init or a mass erase clears it.
  always_ff @(posedge clk or negedge nv_init_n) begin
    if (!nv_init_n) begin
      key_q   <= KEY_BLANK;
      pmask_q <= '1;
    end else if (wipe) begin
      key_q   <= KEY_BLANK;
      pmask_q <= '1;
    end else if (commit) begin
      key_q   <= new_key;
      pmask_q <= new_mask;
    end
  end

  assign keyed        = (key_q != KEY_BLANK);
  assign forever_lock = (key_q == KEY_FOREVER);
endmodule

// File: rtl/fwp_protmap.sv
module fwp_protmap #(
  parameter int GROUPS          = 32,
  parameter int PAGES_PER_GROUP = 2,
  localparam int NUM_PAGES      = GROUPS * PAGES_PER_GROUP
) (
  input  logic [GROUPS-1:0]    vmask,
  input  logic [GROUPS-1:0]    pmask,
  output logic [NUM_PAGES-1:0] page_wr_en
);
  // Active-low masks: a cleared bit in either layer locks its page group.
  for (genvar g = 0; g < GROUPS; g++) begin : g_grp
    logic open_grp;
    assign open_grp = vmask[g] & pmask[g];
    for (genvar p = 0; p < PAGES_PER_GROUP; p++) begin : g_pg
      assign page_wr_en[g*PAGES_PER_GROUP + p] = open_grp;
    end
  end
endmodule

// File: rtl/fwp_seq.sv
module fwp_seq
  import fwp_pkg::*;
#(
  parameter int GROUPS      = 32,
  parameter int NUM_PAGES   = 64,
  parameter int PROT_CYCLES = 4,
  localparam int PAGE_W     = $clog2(NUM_PAGES),
  localparam int CNT_W      = (PROT_CYCLES > 1) ? $clog2(PROT_CYCLES) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cmd_wr,
  input  logic [7:0]           cmd_code,
  input  logic                 mode_ok,
  input  logic [KEY_W-1:0]     presented,
  input  logic [GROUPS-1:0]    stage_mask,
  input  logic [PAGE_W-1:0]    page_idx,
  input  logic [NUM_PAGES-1:0] page_wr_en,
  input  logic [KEY_W-1:0]     stored_key,
  input  logic                 keyed,
  input  logic                 forever_lock,
  input  logic                 op_ready,
  output logic                 busy,
  output logic                 op_valid,
  output op_kind_e             op_kind,
  output logic [PAGE_W-1:0]    op_page,
  output logic                 commit,
  output logic [KEY_W-1:0]     commit_key,
  output logic [GROUPS-1:0]    commit_mask,
  output logic                 wipe,
  output logic                 done_pulse,
  output logic                 fail_pulse
);
  seq_state_e        state_q;
  logic [7:0]        code_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              known_code;
  logic              prot_ok;
  logic              refuse;

  assign known_code = (cmd_code == CMD_PROGRAM) || (cmd_code == CMD_PAGE_ERASE) ||
                      (cmd_code == CMD_MASS_ERASE) || (cmd_code == CMD_PROTECT);

  assign prot_ok = mode_ok && !forever_lock && (!keyed || (presented == stored_key));

  always_comb begin
    refuse = 1'b0;
    if (code_q == CMD_PROTECT) refuse = !prot_ok;
    else if ((code_q == CMD_PROGRAM) || (code_q == CMD_PAGE_ERASE))
      refuse = !page_wr_en[page_idx];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= S_IDLE;
      code_q      <= '0;
      cnt_q       <= '0;
      op_kind     <= OP_PROGRAM;
      op_page     <= '0;
      commit_key  <= KEY_BLANK;
      commit_mask <= '1;
    end else begin
      unique case (state_q)
        S_IDLE: begin
          if (cmd_wr && known_code) begin
            state_q <= S_EVAL;
            code_q  <= cmd_code;
          end
        end
        S_EVAL: begin
          if (refuse) begin
            state_q <= S_IDLE;
          end else if (code_q == CMD_PROTECT) begin
            state_q     <= S_PROG;
            cnt_q       <= CNT_W'(PROT_CYCLES - 1);
            commit_key  <= presented;
            commit_mask <= stage_mask;
          end else begin
            state_q <= S_ISSUE;
            if (code_q == CMD_MASS_ERASE) begin
              op_kind <= OP_MASS_ERASE;
              op_page <= '0;
            end else begin
              op_kind <= (code_q == CMD_PROGRAM) ? OP_PROGRAM : OP_PAGE_ERASE;
              op_page <= page_idx;
            end
          end
        end
        S_PROG: begin
          if (cnt_q == '0) state_q <= S_IDLE;
          else             cnt_q   <= cnt_q - 1'b1;
        end
        S_ISSUE: begin
          if (op_ready) state_q <= S_IDLE;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign busy       = (state_q != S_IDLE);
  assign op_valid   = (state_q == S_ISSUE);
  assign commit     = (state_q == S_PROG) && (cnt_q == '0);
  assign wipe       = op_valid && op_ready && (op_kind == OP_MASS_ERASE);
  assign done_pulse = commit || (op_valid && op_ready);
  assign fail_pulse = (state_q == S_EVAL) && refuse;
endmodule

// File: rtl/fwp_ctrl.sv
module fwp_ctrl
  import fwp_pkg::*;
#(
  parameter int PAGES_PER_GROUP = 2,
  parameter int PROT_CYCLES     = 4,
  parameter int PAGE_LSB        = 9,
  localparam int GROUPS         = DATA_W,
  localparam int NUM_PAGES      = GROUPS * PAGES_PER_GROUP,
  localparam int PAGE_W         = $clog2(NUM_PAGES),
  localparam int HALF_W         = KEY_W / 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 nv_init_n,
  input  logic                 bus_wr,
  input  logic                 bus_rd,
  input  logic [2:0]           bus_sel,
  input  logic [DATA_W-1:0]    bus_wdata,
  output logic [DATA_W-1:0]    bus_rdata,
  output logic [NUM_PAGES-1:0] page_wr_en,
  output logic                 busy,
  output logic                 op_valid,
  input  logic                 op_ready,
  output logic [1:0]           op_kind,
  output logic [PAGE_W-1:0]    op_page
);
  logic              sys_rst_n;
  logic [HALF_W-1:0] addr_q;
  logic [HALF_W-1:0] data_q;
  logic [7:0]        mode_q;
  logic [GROUPS-1:0] vmask_q;
  logic [GROUPS-1:0] stage_q;
  logic              stat_done;
  logic              stat_fail;

  logic [KEY_W-1:0]  presented;
  logic [KEY_W-1:0]  key_q;
  logic [GROUPS-1:0] pmask_q;
  logic              keyed;
  logic              forever_lock;
  logic              key_ok;
  logic              mode_ok;
  logic              commit;
  logic [KEY_W-1:0]  commit_key;
  logic [GROUPS-1:0] commit_mask;
  logic              wipe;
  logic              done_pulse;
  logic              fail_pulse;
  op_kind_e          kind_w;

  assign sys_rst_n = rst_n & nv_init_n;
  assign presented = {addr_q, data_q};
  assign key_ok    = !keyed || (presented == key_q);
  assign mode_ok   = (mode_q[6:5] == 2'b10) && mode_q[3];

  always_ff @(posedge clk or negedge sys_rst_n) begin
    if (!sys_rst_n) begin
      addr_q    <= '0;
      data_q    <= '0;
      mode_q    <= '0;
      vmask_q   <= '1;
      stage_q   <= '1;
      stat_done <= 1'b0;
      stat_fail <= 1'b0;
    end else begin
      if (bus_wr) begin
        unique case (bus_sel)
          RS_ADDR:  addr_q <= bus_wdata[HALF_W-1:0];
          RS_DATA:  data_q <= bus_wdata[HALF_W-1:0];
          RS_MODE:  mode_q <= bus_wdata[7:0];
          RS_VMASK: if (key_ok) vmask_q <= bus_wdata;
          RS_PMASK: if (key_ok) stage_q <= bus_wdata;
          default: ;
        endcase
      end
      if (bus_rd && (bus_sel == RS_STAT)) begin
        stat_done <= 1'b0;
        stat_fail <= 1'b0;
      end
      if (done_pulse) stat_done <= 1'b1;
      if (fail_pulse) begin
        stat_done <= 1'b1;
        stat_fail <= 1'b1;
      end
    end
  end

  fwp_keyvault #(.GROUPS(GROUPS)) u_vault (
    .clk          (clk),
    .nv_init_n    (nv_init_n),
    .commit       (commit),
    .new_key      (commit_key),
    .new_mask     (commit_mask),
    .wipe         (wipe),
    .key_q        (key_q),
    .pmask_q      (pmask_q),
    .keyed        (keyed),
    .forever_lock (forever_lock)
  );

  fwp_protmap #(.GROUPS(GROUPS), .PAGES_PER_GROUP(PAGES_PER_GROUP)) u_map (
    .vmask      (vmask_q),
    .pmask      (pmask_q),
    .page_wr_en (page_wr_en)
  );

  fwp_seq #(.GROUPS(GROUPS), .NUM_PAGES(NUM_PAGES), .PROT_CYCLES(PROT_CYCLES)) u_seq (
    .clk          (clk),
    .rst_n        (sys_rst_n),
    .cmd_wr       (bus_wr && (bus_sel == RS_CMD)),
    .cmd_code     (bus_wdata[7:0]),
    .mode_ok      (mode_ok),
    .presented    (presented),
    .stage_mask   (stage_q),
    .page_idx     (addr_q[PAGE_LSB +: PAGE_W]),
    .page_wr_en   (page_wr_en),
    .stored_key   (key_q),
    .keyed        (keyed),
    .forever_lock (forever_lock),
    .op_ready     (op_ready),
    .busy         (busy),
    .op_valid     (op_valid),
    .op_kind      (kind_w),
    .op_page      (op_page),
    .commit       (commit),
    .commit_key   (commit_key),
    .commit_mask  (commit_mask),
    .wipe         (wipe),
    .done_pulse   (done_pulse),
    .fail_pulse   (fail_pulse)
  );

  assign op_kind = kind_w;

  always_comb begin
    bus_rdata = '0;
    unique case (bus_sel)
      RS_ADDR:  bus_rdata = {{(DATA_W-HALF_W){1'b0}}, addr_q};
      RS_DATA:  bus_rdata = {{(DATA_W-HALF_W){1'b0}}, data_q};
      RS_MODE:  bus_rdata = {{(DATA_W-8){1'b0}}, mode_q};
      RS_STAT:  bus_rdata = {{(DATA_W-5){1'b0}}, forever_lock, keyed, busy, stat_fail, stat_done};
      RS_VMASK: bus_rdata = vmask_q;
      RS_PMASK: bus_rdata = pmask_q;
      default:  bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/fwp_ctrl_chk.sv
module fwp_ctrl_chk
  import fwp_pkg::*;
#(
  parameter int NUM_PAGES = 64,
  parameter int GROUPS    = 32,
  localparam int PAGE_W   = $clog2(NUM_PAGES)
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 bus_wr,
  input logic                 bus_rd,
  input logic [2:0]           bus_sel,
  input logic [DATA_W-1:0]    bus_wdata,
  input logic                 op_valid,
  input logic                 op_ready,
  input logic [1:0]           op_kind,
  input logic [PAGE_W-1:0]    op_page,
  input logic [NUM_PAGES-1:0] page_wr_en,
  input logic                 busy,
  input logic [GROUPS-1:0]    vmask_q,
  input logic [KEY_W-1:0]     key_q,
  input logic                 keyed,
  input logic [KEY_W-1:0]     presented,
  input logic                 stat_done,
  input logic                 stat_fail
);
  logic [NUM_PAGES-1:0] pwe_d;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pwe_d <= '1;
    else        pwe_d <= page_wr_en;
  end

  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && !op_ready) |=> (op_valid && $stable(op_kind) && $stable(op_page)));

  a_r9_refuse: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(op_valid) && (op_kind != OP_MASS_ERASE)) |-> pwe_d[op_page]);

  a_r3_direct: assert property (@(posedge clk) disable iff (!rst_n)
    (!keyed && bus_wr && (bus_sel == RS_VMASK)) |=> (vmask_q == $past(bus_wdata)));

  a_r6_keyed_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (keyed && bus_wr && (bus_sel == RS_VMASK) && (presented != key_q)) |=> $stable(vmask_q));

  a_r8_forever: assert property (@(posedge clk) disable iff (!rst_n)
    ((key_q == KEY_FOREVER) && !(op_valid && op_ready && (op_kind == OP_MASS_ERASE)))
      |=> (key_q == KEY_FOREVER));

  a_r10_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && (bus_sel == RS_STAT) && !busy) |=> (!stat_done && !stat_fail));
endmodule

bind fwp_ctrl fwp_ctrl_chk #(.NUM_PAGES(NUM_PAGES), .GROUPS(GROUPS)) u_chk (
  .clk        (clk),
  .rst_n      (sys_rst_n),
  .bus_wr     (bus_wr),
  .bus_rd     (bus_rd),
  .bus_sel    (bus_sel),
  .bus_wdata  (bus_wdata),
  .op_valid   (op_valid),
  .op_ready   (op_ready),
  .op_kind    (op_kind),
  .op_page    (op_page),
  .page_wr_en (page_wr_en),
  .busy       (busy),
  .vmask_q    (vmask_q),
  .key_q      (key_q),
  .keyed      (keyed),
  .presented  (presented),
  .stat_done  (stat_done),
  .stat_fail  (stat_fail)
);

// File: tb/tb_fwp_ctrl.sv
module tb_fwp_ctrl;
  localparam int NPG = 64;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        nv_init_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [2:0]  bus_sel = 3'd0;
  logic [31:0] bus_wdata = 32'd0;
  logic [31:0] bus_rdata;
  logic [NPG-1:0] page_wr_en;
  logic        busy;
  logic        op_valid;
  logic        op_ready = 1'b0;
  logic [1:0]  op_kind;
  logic [5:0]  op_page;

  always #5 clk = ~clk;

  fwp_ctrl dut (
    .clk(clk), .rst_n(rst_n), .nv_init_n(nv_init_n),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_sel(bus_sel),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .page_wr_en(page_wr_en), .busy(busy),
    .op_valid(op_valid), .op_ready(op_ready),
    .op_kind(op_kind), .op_page(op_page)
  );

  typedef struct {
    int          kind;
    logic [63:0] exp;
    string       req;
  } item_t;

  item_t sb_q[$];
  logic  probe = 1'b0;
  int    vectors = 0;
  int    miscompares = 0;
  bit    ended = 1'b0;

  task automatic push(input int kind, input logic [63:0] exp, input string req);
    item_t it;
    it.kind = kind;
    it.exp  = exp;
    it.req  = req;
    sb_q.push_back(it);
  endtask

  task automatic wr(input logic [2:0] sel, input logic [31:0] d);
    @(posedge clk); #1;
    bus_wr = 1'b1; bus_sel = sel; bus_wdata = d;
    @(posedge clk); #1;
    bus_wr = 1'b0;
  endtask

  task automatic rd_exp(input logic [2:0] sel, input logic [31:0] exp, input string req);
    @(posedge clk); #1;
    bus_rd = 1'b1; bus_sel = sel;
    push(0, {32'd0, exp}, req);
    probe = 1'b1;
    @(posedge clk); #1;
    bus_rd = 1'b0; probe = 1'b0;
  endtask

  task automatic pages_exp(input logic [63:0] exp, input string req);
    @(posedge clk); #1;
    push(1, exp, req);
    probe = 1'b1;
    @(posedge clk); #1;
    probe = 1'b0;
  endtask

  task automatic op_exp(input logic v, input logic [1:0] k, input logic [5:0] pg, input string req);
    @(posedge clk); #1;
    push(2, {55'd0, v, k, pg}, req);
    probe = 1'b1;
    @(posedge clk); #1;
    probe = 1'b0;
  endtask

  task automatic ready_pulse();
    @(posedge clk); #1; op_ready = 1'b1;
    @(posedge clk); #1; op_ready = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1'b1;
      if (sb_q.size() != 0) begin
        miscompares++;
        $display("FAIL R1 scoreboard actual=%0d pending expected=0", sb_q.size());
      end
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  endtask

  // Monitor: pops one expectation per probed cycle, samples on the falling edge.
  always @(negedge clk) begin
    if (probe) begin
      item_t it;
      logic [63:0] act;
      if (sb_q.size() == 0) begin
        miscompares++;
        $display("FAIL R1 scoreboard actual=empty expected=item");
      end else begin
        it = sb_q.pop_front();
        case (it.kind)
          0:       act = {32'd0, bus_rdata};
          1:       act = page_wr_en;
          default: act = {55'd0, op_valid, op_kind, op_page};
        endcase
        if (it.kind == 2 && it.exp[8] == 1'b0) act = act & 64'h100;
        vectors++;
        if (act !== it.exp) begin
          miscompares++;
          $display("FAIL %s actual=%h expected=%h", it.req, act, it.exp);
        end
      end
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    miscompares++;
    $display("FAIL R1 watchdog actual=running expected=finished");
    finish_run();
  end

  localparam logic [2:0] S_ADDR = 3'd0, S_DATA = 3'd1, S_MODE = 3'd2, S_CMD = 3'd3,
                         S_STAT = 3'd4, S_VM = 3'd5, S_PM = 3'd6;
  localparam logic [63:0] ALL = 64'hFFFF_FFFF_FFFF_FFFF;

  initial begin
    repeat (3) @(posedge clk);
    #1; nv_init_n = 1'b1; rst_n = 1'b1;

    // R1 reset state
    pages_exp(ALL, "R1 pages");
    rd_exp(S_STAT, 32'h0, "R1 status");
    rd_exp(S_VM, 32'hFFFF_FFFF, "R1 vmask");
    rd_exp(S_PM, 32'hFFFF_FFFF, "R1 pmask");
    op_exp(1'b0, 2'd0, 6'd0, "R1 op idle");

    // R2/R3 direct volatile write protects pages 2,3
    wr(S_VM, 32'hFFFF_FFFD);
    pages_exp(~64'hC, "R2 vmask pair1");
    rd_exp(S_VM, 32'hFFFF_FFFD, "R3 vmask readback");

    // R9 refused program on page 3
    wr(S_ADDR, 32'd3 << 9);
    wr(S_CMD, 32'h02);
    rd_exp(S_STAT, 32'h3, "R9 refused program");
    op_exp(1'b0, 2'd0, 6'd0, "R9 no op issued");
    rd_exp(S_STAT, 32'h0, "R10 sticky cleared");

    // R9 page erase on open page 6, back-pressure then handshake
    wr(S_ADDR, 32'd6 << 9);
    wr(S_CMD, 32'h03);
    op_exp(1'b1, 2'd1, 6'd6, "R9 erase issued");
    op_exp(1'b1, 2'd1, 6'd6, "R9 erase held");
    ready_pulse();
    op_exp(1'b0, 2'd0, 6'd0, "R9 op retired");
    rd_exp(S_STAT, 32'h1, "R9 done");

    // R3 warm reset clears volatile mask
    @(posedge clk); #1; rst_n = 1'b0;
    repeat (2) @(posedge clk); #1; rst_n = 1'b1;
    pages_exp(ALL, "R3 warm reset pages");
    rd_exp(S_VM, 32'hFFFF_FFFF, "R3 warm reset vmask");

    // R5 protect with wrong mode bits
    wr(S_PM, 32'hFFFF_FFFB);
    wr(S_ADDR, 32'h66BB);
    wr(S_DATA, 32'hAA55);
    wr(S_MODE, 32'h40);
    wr(S_CMD, 32'h0C);
    rd_exp(S_STAT, 32'h3, "R5 one-cycle fail");
    rd_exp(S_PM, 32'hFFFF_FFFF, "R5 pmask unchanged");
    pages_exp(ALL, "R5 pages unchanged");

    // R4 protect stores key and mask
    wr(S_MODE, 32'h48);
    wr(S_CMD, 32'h0C);
    rd_exp(S_STAT, 32'h4, "R4 busy");
    idle(8);
    rd_exp(S_STAT, 32'h9, "R4 done keyed");
    rd_exp(S_PM, 32'hFFFF_FFFB, "R4 pmask committed");
    pages_exp(~64'h30, "R4 pages 4,5 locked");

    // R6 keyed volatile writes need the key
    wr(S_ADDR, 32'h0);
    wr(S_VM, 32'hFFFF_FFFE);
    pages_exp(~64'h30, "R6 wrong key ignored");
    rd_exp(S_VM, 32'hFFFF_FFFF, "R6 vmask unchanged");
    wr(S_ADDR, 32'h66BB);
    wr(S_VM, 32'hFFFF_FFFE);
    pages_exp(~64'h33, "R6 matching key accepted");

    // R3 warm reset keeps key and persistent mask
    @(posedge clk); #1; rst_n = 1'b0;
    repeat (2) @(posedge clk); #1; rst_n = 1'b1;
    pages_exp(~64'h30, "R3 persistent kept");
    rd_exp(S_STAT, 32'h8, "R3 key kept");

    // R7 wrong key fails, matching key changes mask; R11 busy ignore
    wr(S_ADDR, 32'h66BB);
    wr(S_DATA, 32'hAA55);
    wr(S_MODE, 32'h48);
    wr(S_PM, 32'hFFFF_FFFF);
    wr(S_ADDR, 32'h1111);
    wr(S_CMD, 32'h0C);
    rd_exp(S_STAT, 32'hB, "R7 wrong key fails");
    rd_exp(S_PM, 32'hFFFF_FFFB, "R7 pmask unchanged");
    wr(S_ADDR, 32'h66BB);
    wr(S_CMD, 32'h0C);
    wr(S_CMD, 32'h05);
    idle(8);
    rd_exp(S_STAT, 32'h9, "R11 key survives ignored erase");
    op_exp(1'b0, 2'd0, 6'd0, "R11 no op issued");
    rd_exp(S_PM, 32'hFFFF_FFFF, "R7 mask replaced");
    pages_exp(ALL, "R7 pages open");

    // R8 mass erase, then permanent key
    wr(S_CMD, 32'h05);
    op_exp(1'b1, 2'd2, 6'd0, "R8 mass erase issued");
    ready_pulse();
    rd_exp(S_STAT, 32'h1, "R8 key erased");
    wr(S_PM, 32'hFFFF_FFFE);
    wr(S_ADDR, 32'hDEAD);
    wr(S_DATA, 32'hDEAD);
    wr(S_CMD, 32'h0C);
    idle(8);
    rd_exp(S_STAT, 32'h19, "R8 permanent set");
    pages_exp(~64'h3, "R8 pair0 locked");
    wr(S_PM, 32'hFFFF_FFFF);
    wr(S_CMD, 32'h0C);
    rd_exp(S_STAT, 32'h1B, "R8 protect refused");
    rd_exp(S_PM, 32'hFFFF_FFFE, "R8 mask stays");
    wr(S_CMD, 32'h05);
    op_exp(1'b1, 2'd2, 6'd0, "R8 second mass erase");
    ready_pulse();
    rd_exp(S_STAT, 32'h1, "R8 lock removed");
    rd_exp(S_PM, 32'hFFFF_FFFF, "R8 mask blank");
    pages_exp(ALL, "R8 pages open");

    idle(2);
    finish_run();
  end
endmodule